// File: doc/BRIEF.md
# Polled Console Keyboard and Display Controller

This block is a bus slave that connects one keyboard-style character source and one display-style character sink to a CPU that polls. Each direction holds a single character. The CPU sees four word registers in a fixed window at the top of the address space. It waits on a hardware-owned ready flag before it takes a received character or hands over one to print.

On the receive side, a character comes in with a one-cycle valid strobe. The block latches the character and raises the keyboard ready flag. When the CPU reads the keyboard data register, the flag drops. If a second character arrives before the first is taken, the new one replaces it and a sticky overrun flag is set.

On the transmit side, a CPU write to the display data register is accepted only while display ready is 1. The accepted byte is presented to the sink with a valid signal until the sink acknowledges. Each channel also has a software-writable enable bit. The channel's interrupt request is the AND of that enable bit and the channel's ready flag.

Top module: `console_mmio`

## Requirements
- R1: The four registers decode on a full 32-bit address match:
  - keyboard status at 0xFFFF0000
  - keyboard data at 0xFFFF0004
  - display status at 0xFFFF0008
  - display data at 0xFFFF000C

  Any other address, including a misaligned one such as 0xFFFF0001, reads as 0, and a write to it changes nothing.
- R2: After reset:
  - keyboard status reads 0
  - display status reads 1 (ready, with interrupts disabled)
  - `dsp_valid` is 0
  - both interrupt requests are 0
- R3: On the clock edge where `kb_valid` is 1, the block latches `kb_char`. From the next cycle, keyboard status bit 0 (ready) is 1. The keyboard data register then reads the character in bits 7:0, with bits 31:8 equal to 0.
- R4: A keyboard data read (`bus_re` = 1 at 0xFFFF0004) clears keyboard ready and overrun on the next cycle. If `kb_valid` is 1 in the same cycle, ready stays 1, the new character is held, and overrun is 0.
- R5: A character that arrives while keyboard ready is 1, with no data read in that cycle, replaces the held character and sets keyboard status bit 2 (overrun). Overrun stays 1 until the next keyboard data read.
- R6: A write to the display data register while display ready is 1 has these effects from the next cycle:
  - display status bit 0 reads 0
  - `dsp_valid` is 1
  - `dsp_char` carries `bus_wdata[7:0]`
- R7: While `dsp_valid` is 1 and `dsp_ack` is 0, `dsp_char` stays unchanged. The cycle after `dsp_ack` is 1, display ready is 1 again and `dsp_valid` is 0.
- R8: A write to the display data register while display ready is 0 is ignored. The presented byte does not change.
- R9: For each channel:
  - status bit 1 is an interrupt enable, set from `bus_wdata[1]` by a status write
  - a status write does not change bit 0 (ready) or bit 2 (overrun)
  - status bits 31:3 always read 0, and bit 2 of the display status also reads 0
- R10: `irq_kb` is 1 exactly when keyboard ready and keyboard enable are both 1. `irq_dsp` is 1 exactly when display ready and display enable are both 1.
- R11: The display data register reads the last accepted byte in bits 7:0, with bits 31:8 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | CPU byte address |
| bus_we | input | 1 | CPU write strobe |
| bus_re | input | 1 | CPU read strobe (side effect on keyboard data) |
| bus_wdata | input | 32 | CPU write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| kb_valid | input | 1 | Incoming character strobe |
| kb_char | input | 8 | Incoming character |
| dsp_valid | output | 1 | Byte presented to the display sink |
| dsp_char | output | 8 | Presented byte |
| dsp_ack | input | 1 | Sink has taken the presented byte |
| irq_kb | output | 1 | Keyboard interrupt request |
| irq_dsp | output | 1 | Display interrupt request |

## Verification
The assertions in the channel modules check the following on every cycle:
- the set and clear rules of both ready flags
- the setting of overrun
- that status writes never touch ready
- that the presented display byte holds until acknowledged

Some behaviours can only be shown by the bench scenarios, because they depend on the bus view rather than on one channel's flags:
- the address decode, including misaligned and out-of-window addresses
- the exact read-data layout of each register
- the interaction between a data read and an arrival in the same cycle
- the interrupt outputs across enable changes

The bench compares every cycle against a behavioural model under both directed and random traffic.

// File: rtl/console_pkg.sv
package console_pkg;

    typedef enum logic [2:0] {
        SEL_NONE  = 3'd0,
        SEL_KSTAT = 3'd1,
        SEL_KDATA = 3'd2,
        SEL_DSTAT = 3'd3,
        SEL_DDATA = 3'd4
    } reg_sel_e;

    // Bit 2: overrun, bit 1: interrupt enable, bit 0: ready
    typedef struct packed {
        logic ovr;
        logic ie;
        logic rdy;
    } chan_stat_t;

    localparam int STAT_W = 3;
    localparam int IE_BIT = 1;

endpackage

// File: rtl/con_decode.sv
module con_decode
    import console_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] A_KSTAT = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] A_KDATA = ADDR_W'(BASE + 32'd4);
    localparam logic [ADDR_W-1:0] A_DSTAT = ADDR_W'(BASE + 32'd8);
    localparam logic [ADDR_W-1:0] A_DDATA = ADDR_W'(BASE + 32'd12);

    always_comb begin
        if (addr == A_KSTAT)      sel = SEL_KSTAT;
        else if (addr == A_KDATA) sel = SEL_KDATA;
        else if (addr == A_DSTAT) sel = SEL_DSTAT;
        else if (addr == A_DDATA) sel = SEL_DDATA;
        else                      sel = SEL_NONE;
    end
endmodule

// File: rtl/con_kbd_chan.sv
module con_kbd_chan
    import console_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              rd_data,
    input  logic              wr_stat,
    input  logic              ie_in,
    output chan_stat_t        stat,
    output logic [CHAR_W-1:0] held_char
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat      <= '0;
            held_char <= '0;
        end else begin
            if (wr_stat) stat.ie <= ie_in;
            if (in_valid) begin
                held_char <= in_char;
                stat.rdy  <= 1'b1;
                stat.ovr  <= rd_data ? 1'b0 : (stat.rdy | stat.ovr);
            end else if (rd_data) begin
                stat.rdy <= 1'b0;
                stat.ovr <= 1'b0;
            end
        end
    end

    // R3
    kb_set_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (stat.rdy && held_char == $past(in_char)));
    // R4
    kb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_data && !in_valid) |=> (!stat.rdy && !stat.ovr));
    // R5
    kb_ovr_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && stat.rdy && !rd_data) |=> stat.ovr);
    // R9
    kb_rdy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !rd_data) |=> $stable(stat.rdy));
endmodule

// File: rtl/con_dsp_chan.sv
module con_dsp_chan
    import console_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic [CHAR_W-1:0] wr_byte,
    input  logic              wr_stat,
    input  logic              ie_in,
    input  logic              ack,
    output chan_stat_t        stat,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stat     <= '{ovr: 1'b0, ie: 1'b0, rdy: 1'b1};
            out_char <= '0;
        end else begin
            if (wr_stat) stat.ie <= ie_in;
            if (!stat.rdy && ack) begin
                stat.rdy <= 1'b1;
            end else if (stat.rdy && wr_data) begin
                stat.rdy <= 1'b0;
                out_char <= wr_byte;
            end
        end
    end

    assign out_valid = !stat.rdy;

    // R6
    dsp_take_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_data && stat.rdy) |=> (out_valid && out_char == $past(wr_byte)));
    // R7
    dsp_done_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && ack) |=> stat.rdy);
    // R8
    dsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ack) |=> (out_valid && $stable(out_char)));
    // R9
    dsp_ovr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stat |=> !stat.ovr);
endmodule

// File: rtl/console_mmio.sv
module console_mmio
    import console_pkg::*;
#(
    parameter int          ADDR_W = 32,
    parameter int          DATA_W = 32,
    parameter int          CHAR_W = 8,
    parameter logic [31:0] BASE   = 32'hFFFF_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [CHAR_W-1:0] kb_char,
    output logic              dsp_valid,
    output logic [CHAR_W-1:0] dsp_char,
    input  logic              dsp_ack,
    output logic              irq_kb,
    output logic              irq_dsp
);
    localparam int PAD_STAT = DATA_W - STAT_W;
    localparam int PAD_CHAR = DATA_W - CHAR_W;

    reg_sel_e          sel;
    chan_stat_t        kst, dst;
    logic [CHAR_W-1:0] k_char;

    con_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
        .addr(bus_addr), .sel(sel)
    );

    con_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (kb_valid),
        .in_char   (kb_char),
        .rd_data   (bus_re && sel == SEL_KDATA),
        .wr_stat   (bus_we && sel == SEL_KSTAT),
        .ie_in     (bus_wdata[IE_BIT]),
        .stat      (kst),
        .held_char (k_char)
    );

    con_dsp_chan #(.CHAR_W(CHAR_W)) u_dsp (
        .clk       (clk),
        .rst       (rst),
        .wr_data   (bus_we && sel == SEL_DDATA),
        .wr_byte   (bus_wdata[CHAR_W-1:0]),
        .wr_stat   (bus_we && sel == SEL_DSTAT),
        .ie_in     (bus_wdata[IE_BIT]),
        .ack       (dsp_ack),
        .stat      (dst),
        .out_valid (dsp_valid),
        .out_char  (dsp_char)
    );

    always_comb begin
        unique case (sel)
            SEL_KSTAT: bus_rdata = {{PAD_STAT{1'b0}}, kst};
            SEL_KDATA: bus_rdata = {{PAD_CHAR{1'b0}}, k_char};
            SEL_DSTAT: bus_rdata = {{PAD_STAT{1'b0}}, dst};
            SEL_DDATA: bus_rdata = {{PAD_CHAR{1'b0}}, dsp_char};
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_kb  = kst.rdy & kst.ie;
    assign irq_dsp = dst.rdy & dst.ie;

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata[DATA_W-1:CHAR_W];

    // R1
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_console_mmio.sv
module sim_console_mmio;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] KS = 32'hFFFF_0000;
    localparam logic [31:0] KD = 32'hFFFF_0004;
    localparam logic [31:0] DS = 32'hFFFF_0008;
    localparam logic [31:0] DD = 32'hFFFF_000C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_char = '0;
    logic        dsp_valid;
    logic [7:0]  dsp_char;
    logic        dsp_ack = 1'b0;
    logic        irq_kb, irq_dsp;

    int total = 0, bad = 0, cycles = 0;
    bit done = 1'b0;

    // behavioural reference state
    bit       m_kr, m_ko, m_ki, m_dr, m_di;
    bit [7:0] m_kc, m_dc;

    always #(CLK_PERIOD/2) clk = ~clk;

    console_mmio u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kb_valid(kb_valid),
        .kb_char(kb_char), .dsp_valid(dsp_valid), .dsp_char(dsp_char),
        .dsp_ack(dsp_ack), .irq_kb(irq_kb), .irq_dsp(irq_dsp)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_kr = 0; m_ko = 0; m_ki = 0; m_kc = 0;
            m_dr = 1; m_di = 0; m_dc = 0;
        end else begin
            bit kread;
            kread = bus_re && bus_addr == KD;
            if (bus_we && bus_addr == KS) m_ki = bus_wdata[1];
            if (bus_we && bus_addr == DS) m_di = bus_wdata[1];
            if (kb_valid) begin
                m_ko = kread ? 1'b0 : (m_kr | m_ko);
                m_kr = 1; m_kc = kb_char;
            end else if (kread) begin
                m_kr = 0; m_ko = 0;
            end
            if (!m_dr && dsp_ack) m_dr = 1;
            else if (m_dr && bus_we && bus_addr == DD) begin
                m_dr = 0; m_dc = bus_wdata[7:0];
            end
        end
    end

    function automatic logic [31:0] model_read(logic [31:0] a);
        if (a == KS) return {29'b0, m_ko, m_ki, m_kr};
        if (a == KD) return {24'b0, m_kc};
        if (a == DS) return {30'b0, m_di, m_dr};
        if (a == DD) return {24'b0, m_dc};
        return 32'b0;
    endfunction

    function automatic string read_tag(logic [31:0] a);
        if (a == KS || a == KD) return "R3";
        if (a == DS) return "R6";
        if (a == DD) return "R11";
        return "R1";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // one clock, then compare all outputs with the model away from the edge
    task automatic cyc();
        @(posedge clk);
        #1;
        chk(read_tag(bus_addr), bus_rdata, model_read(bus_addr));
        chk("R10 irq_kb", {31'b0, irq_kb}, {31'b0, m_kr & m_ki});
        chk("R10 irq_dsp", {31'b0, irq_dsp}, {31'b0, m_dr & m_di});
        chk("R7 dsp_valid", {31'b0, dsp_valid}, {31'b0, !m_dr});
        chk("R6 dsp_char", {24'b0, dsp_char}, {24'b0, m_dc});
    endtask

    task automatic idle();
        bus_we = 0; bus_re = 0; kb_valid = 0; dsp_ack = 0; bus_wdata = '0;
    endtask

    task automatic peek(logic [31:0] a, logic [31:0] exp, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic kb_send(logic [7:0] c);
        kb_valid = 1; kb_char = c; cyc(); idle();
    endtask

    task automatic bus_write(logic [31:0] a, logic [31:0] d);
        bus_addr = a; bus_we = 1; bus_wdata = d; cyc(); idle();
    endtask

    task automatic bus_read(logic [31:0] a);
        bus_addr = a; bus_re = 1; cyc(); idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) cyc();
        rst = 0;
        cyc();
        // R2 reset state
        peek(KS, 32'h0, "R2 kstat");
        peek(DS, 32'h1, "R2 dstat");
        chk("R2 dsp_valid", {31'b0, dsp_valid}, 32'h0);
        // R1 unmapped and misaligned
        peek(32'hFFFF_0010, 32'h0, "R1 unmapped");
        peek(32'hFFFF_0009, 32'h0, "R1 misaligned");
        // R3 arrival
        kb_send(8'h41);
        peek(KS, 32'h1, "R3 ready");
        peek(KD, 32'h41, "R3 data");
        // R4 read clears
        bus_read(KD);
        peek(KS, 32'h0, "R4 cleared");
        // R5 overrun
        kb_send(8'h11);
        kb_send(8'h22);
        peek(KS, 32'h5, "R5 overrun");
        peek(KD, 32'h22, "R5 replaced");
        // R9 status write only changes enable
        bus_write(KS, 32'hFFFF_FFFF);
        peek(KS, 32'h7, "R9 ie only");
        chk("R10 irq_kb on", {31'b0, irq_kb}, 32'h1);
        // R4 read with simultaneous arrival
        bus_addr = KD; bus_re = 1; kb_valid = 1; kb_char = 8'h33; cyc(); idle();
        peek(KS, 32'h3, "R4 read+arrive");
        peek(KD, 32'h33, "R4 new char");
        bus_read(KD);
        peek(KS, 32'h2, "R4 cleared again");
        chk("R10 irq_kb off", {31'b0, irq_kb}, 32'h0);
        // R1 writes to unmapped/misaligned do not clear enable
        bus_write(32'hFFFF_0001, 32'h0);
        bus_write(32'hFFFF_0014, 32'h0);
        peek(KS, 32'h2, "R1 write ignored");
        // R6 display write
        bus_write(DD, 32'hABCD_EF5A);
        peek(DS, 32'h0, "R6 busy");
        chk("R6 valid", {31'b0, dsp_valid}, 32'h1);
        chk("R6 char", {24'b0, dsp_char}, 32'h5A);
        // R8 write while busy ignored
        bus_write(DD, 32'h77);
        chk("R8 char held", {24'b0, dsp_char}, 32'h5A);
        peek(DD, 32'h5A, "R11 readback");
        cyc(); cyc();
        // R7 ack
        dsp_ack = 1; cyc(); idle();
        peek(DS, 32'h1, "R7 ready again");
        chk("R7 valid low", {31'b0, dsp_valid}, 32'h0);
        bus_write(DS, 32'h2);
        peek(DS, 32'h3, "R9 dsp ie");
        chk("R10 irq_dsp", {31'b0, irq_dsp}, 32'h1);
        // random traffic against the model
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] addrs [6];
            addrs = '{KS, KD, DS, DD, 32'hFFFF_0010, 32'hFFFF_0002};
            bus_addr  = addrs[$urandom_range(0, 5)];
            bus_we    = ($urandom_range(0, 3) == 0);
            bus_re    = ($urandom_range(0, 2) == 0);
            bus_wdata = $urandom;
            kb_valid  = ($urandom_range(0, 3) == 0);
            kb_char   = 8'($urandom);
            dsp_ack   = ($urandom_range(0, 2) == 0);
            cyc();
        end
        idle();
        cyc();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule